// File: doc/BRIEF.md
# Two-Digit Decimal Adder with Invalid-Digit Flag

This block adds two packed two-digit decimal operands, each held as a tens nibble over a units nibble, together with a one-bit carry input. It returns a two-digit decimal sum, a carry-out that acts as the hundreds digit, and an error flag. The block is purely combinational. It has no clock and no reset, so its outputs follow its inputs within one propagation delay.

Every operand nibble is checked before its result is used. When any of the four nibbles holds a code from 10 to 15, the sum and carry-out are both driven to zero and the error flag is raised. When all four nibbles are valid, the flag is low and the outputs carry the true decimal result.

A parameter selects one of two datapaths. The first chains one-digit stages from the units digit upward. Each stage is a full-adder nibble sum with a +6 correction. The second converts each operand to binary, adds the two with the carry input, and converts the total back to decimal digits. Both datapaths produce the same port behaviour.

Top module: `bcd2_adder`

## Requirements
- R1: With all operand nibbles valid (0 to 9), `{carryOut, sumOut}` equals the decimal value of `opA` plus that of `opB` plus `carryIn`. `carryOut` is the hundreds digit, `sumOut[7:4]` is the tens digit and `sumOut[3:0]` is the units digit.
- R2: When any nibble of `opA` or `opB` (bits 7:4 or 3:0) holds 10 to 15, `sumOut` is 0, `carryOut` is 0 and `errFlag` is 1, whatever the carry input.
- R3: When all four operand nibbles are valid, `errFlag` is 0.
- R4: The largest result, 99 + 99 + 1, gives `carryOut` = 1 and `sumOut` = 8'h99.
- R5: A units-digit sum above 9, including one whose binary nibble sum passes 15 (such as 9 + 9 + 1), is corrected by 6 and carries one into the tens digit.
- R6: The binary-conversion datapath (`BINARY_PATH` = 1) gives the same outputs as the chained-stage datapath for every input.
- R7: Every output digit, valid or forced, is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First operand: tens nibble in bits 7:4, units nibble in bits 3:0 |
| opB | input | 8 | Second operand, same packing as `opA` |
| carryIn | input | 1 | Carry added into the units digit |
| sumOut | output | 8 | Decimal sum: tens in bits 7:4, units in bits 3:0 |
| carryOut | output | 1 | Hundreds digit of the result |
| errFlag | output | 1 | High when any operand nibble is not a valid decimal digit |

## Verification
The bench sweeps every valid operand pair with both carry-in values. A correction rule that only tests the nibble sum against 9 would miss the sums of 16 to 19, which wrap inside the nibble. Such a design would print a units digit of 0 to 3 with no carry for cases like 9 + 9. A missing inter-stage carry would lose ten on cases like 05 + 05.

Invalid codes 10 to 15 are placed in each of the four nibble positions in turn. A validity check that skips one position, or that uses a limit of 10 instead of 9, leaves a non-zero sum or a low flag there. The binary-conversion variant is compared against the same expected values. An off-by-one in its back-conversion shows up near 100 and 199.

// File: rtl/bcd_add_pkg.sv
`timescale 1ns/1ps
package bcd_add_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DIGIT_MAX = 9;
  localparam int DIGIT_FIX = 6;

  typedef logic [DIGIT_W-1:0] digit_t;

  // Strobes from the operand checker to the datapath
  typedef struct packed {
    logic zeroOut;
    logic raiseErr;
  } ctrl_t;

  function automatic logic digitOk(input digit_t d);
    return d <= digit_t'(DIGIT_MAX);
  endfunction
endpackage

// File: rtl/bcd_digit_stage.sv
`timescale 1ns/1ps
module bcd_digit_stage
  import bcd_add_pkg::*;
(
  input  digit_t aDigit,
  input  digit_t bDigit,
  input  logic   cIn,
  output digit_t sDigit,
  output logic   cOut
);
  logic [DIGIT_W:0]   chain;
  logic [DIGIT_W-1:0] rawSum;
  logic               needFix;

  assign chain[0] = cIn;

  genvar i;
  generate
    for (i = 0; i < DIGIT_W; i++) begin : g_fa
      assign rawSum[i]  = aDigit[i] ^ bDigit[i] ^ chain[i];
      assign chain[i+1] = (aDigit[i] & bDigit[i]) | (chain[i] & (aDigit[i] ^ bDigit[i]));
    end
  endgenerate

  // Sum above 9: either the nibble wrapped, or it reads 10..15
  assign needFix = chain[DIGIT_W] | (rawSum > digit_t'(DIGIT_MAX));
  assign sDigit  = needFix ? digit_t'(rawSum + digit_t'(DIGIT_FIX)) : rawSum;
  assign cOut    = needFix;
endmodule

// File: rtl/bcd_operand_check.sv
`timescale 1ns/1ps
module bcd_operand_check
  import bcd_add_pkg::*;
#(
  parameter int NUM_DIGITS = 2
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] opA,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] opB,
  output ctrl_t                         ctrl
);
  logic [2*NUM_DIGITS-1:0] badNibble;

  genvar k;
  generate
    for (k = 0; k < NUM_DIGITS; k++) begin : g_chk
      assign badNibble[2*k]   = !digitOk(opA[k*DIGIT_W +: DIGIT_W]);
      assign badNibble[2*k+1] = !digitOk(opB[k*DIGIT_W +: DIGIT_W]);
    end
  endgenerate

  assign ctrl.raiseErr = |badNibble;
  assign ctrl.zeroOut  = |badNibble;
endmodule

// File: rtl/bcd_sum_path.sv
`timescale 1ns/1ps
module bcd_sum_path
  import bcd_add_pkg::*;
#(
  parameter int NUM_DIGITS  = 2,
  parameter bit BINARY_PATH = 1'b0
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] opA,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] opB,
  input  logic                          cIn,
  input  ctrl_t                         ctrl,
  output logic [NUM_DIGITS*DIGIT_W-1:0] sumOut,
  output logic                          carryOut,
  output logic                          errOut
);
  localparam int OP_W  = NUM_DIGITS * DIGIT_W;
  localparam int BIN_W = $clog2(2 * (10 ** NUM_DIGITS));
  localparam int DD_W  = (NUM_DIGITS + 1) * DIGIT_W;

  logic [OP_W-1:0] rawSum;
  logic            rawCarry;

  generate
    if (!BINARY_PATH) begin : g_ripple
      logic [NUM_DIGITS:0] link;
      assign link[0] = cIn;
      for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_stage
        bcd_digit_stage u_stage (
          .aDigit(opA[d*DIGIT_W +: DIGIT_W]),
          .bDigit(opB[d*DIGIT_W +: DIGIT_W]),
          .cIn   (link[d]),
          .sDigit(rawSum[d*DIGIT_W +: DIGIT_W]),
          .cOut  (link[d+1])
        );
      end
      assign rawCarry = link[NUM_DIGITS];
    end else begin : g_binary
      logic [BIN_W-1:0] binA, binB, binTotal;
      logic [DD_W-1:0]  ddOut;

      always_comb begin
        binA = '0;
        binB = '0;
        for (int d = NUM_DIGITS - 1; d >= 0; d--) begin
          binA = BIN_W'(binA * BIN_W'(10)) + BIN_W'(opA[d*DIGIT_W +: DIGIT_W]);
          binB = BIN_W'(binB * BIN_W'(10)) + BIN_W'(opB[d*DIGIT_W +: DIGIT_W]);
        end
        binTotal = binA + binB + BIN_W'(cIn);
      end

      // Shift-and-add-3 back to decimal digits
      always_comb begin
        ddOut = '0;
        for (int i = BIN_W - 1; i >= 0; i--) begin
          for (int d = 0; d <= NUM_DIGITS; d++) begin
            if (ddOut[d*DIGIT_W +: DIGIT_W] >= digit_t'(5))
              ddOut[d*DIGIT_W +: DIGIT_W] = ddOut[d*DIGIT_W +: DIGIT_W] + digit_t'(3);
          end
          ddOut = {ddOut[DD_W-2:0], binTotal[i]};
        end
      end

      assign rawSum   = ddOut[OP_W-1:0];
      assign rawCarry = |ddOut[DD_W-1:OP_W];
    end
  endgenerate

  assign sumOut   = ctrl.zeroOut ? '0 : rawSum;
  assign carryOut = ctrl.zeroOut ? 1'b0 : rawCarry;
  assign errOut   = ctrl.raiseErr;
endmodule

// File: rtl/bcd2_adder.sv
`timescale 1ns/1ps
module bcd2_adder
  import bcd_add_pkg::*;
#(
  parameter int NUM_DIGITS  = 2,
  parameter bit BINARY_PATH = 1'b0
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] opA,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] opB,
  input  logic                          carryIn,
  output logic [NUM_DIGITS*DIGIT_W-1:0] sumOut,
  output logic                          carryOut,
  output logic                          errFlag
);
  ctrl_t ctrl;

  bcd_operand_check #(.NUM_DIGITS(NUM_DIGITS)) u_check (
    .opA (opA),
    .opB (opB),
    .ctrl(ctrl)
  );

  bcd_sum_path #(.NUM_DIGITS(NUM_DIGITS), .BINARY_PATH(BINARY_PATH)) u_path (
    .opA     (opA),
    .opB     (opB),
    .cIn     (carryIn),
    .ctrl    (ctrl),
    .sumOut  (sumOut),
    .carryOut(carryOut),
    .errOut  (errFlag)
  );
endmodule

// File: rtl/bcd2_adder_chk.sv
`timescale 1ns/1ps
module bcd2_adder_chk
  import bcd_add_pkg::*;
#(
  parameter int NUM_DIGITS = 2
) (
  input logic [NUM_DIGITS*DIGIT_W-1:0] opA,
  input logic [NUM_DIGITS*DIGIT_W-1:0] opB,
  input logic                          carryIn,
  input logic [NUM_DIGITS*DIGIT_W-1:0] sumOut,
  input logic                          carryOut,
  input logic                          errFlag
);
  always_comb begin
    int  valA, valB, valS;
    bit  allOk;
    bit  digitsOk;
    valA = 0; valB = 0; valS = 0;
    allOk = 1'b1; digitsOk = 1'b1;
    for (int d = NUM_DIGITS - 1; d >= 0; d--) begin
      if (opA[d*DIGIT_W +: DIGIT_W] > 4'd9) allOk = 1'b0;
      if (opB[d*DIGIT_W +: DIGIT_W] > 4'd9) allOk = 1'b0;
      if (sumOut[d*DIGIT_W +: DIGIT_W] > 4'd9) digitsOk = 1'b0;
      valA = valA * 10 + int'(opA[d*DIGIT_W +: DIGIT_W]);
      valB = valB * 10 + int'(opB[d*DIGIT_W +: DIGIT_W]);
      valS = valS * 10 + int'(sumOut[d*DIGIT_W +: DIGIT_W]);
    end
    if (!$isunknown({opA, opB, carryIn, sumOut, carryOut, errFlag})) begin
      if (allOk) begin
        assert_decimal_sum_R1: assert (valS + (carryOut ? 10 ** NUM_DIGITS : 0) == valA + valB + int'(carryIn))
          else $error("decimal sum mismatch");
        assert_flag_low_R3: assert (!errFlag)
          else $error("flag raised on valid operands");
      end else begin
        assert_forced_zero_R2: assert (sumOut == '0 && !carryOut && errFlag)
          else $error("invalid operand not forced to zero");
      end
      assert_digit_range_R7: assert (digitsOk)
        else $error("sum digit out of range");
    end
  end
endmodule

bind bcd2_adder bcd2_adder_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .opA     (opA),
  .opB     (opB),
  .carryIn (carryIn),
  .sumOut  (sumOut),
  .carryOut(carryOut),
  .errFlag (errFlag)
);

// File: tb/tb_bcd2_adder.sv
`timescale 1ns/1ps
module tb_bcd2_adder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] opA, opB, sumOut, sumBin;
  logic       carryIn, carryOut, carryBin, errFlag, errBin;

  bcd2_adder #(.NUM_DIGITS(2), .BINARY_PATH(1'b0)) dut (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut), .errFlag(errFlag)
  );

  bcd2_adder #(.NUM_DIGITS(2), .BINARY_PATH(1'b1)) dutBin (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumBin), .carryOut(carryBin), .errFlag(errBin)
  );

  typedef struct {
    string      tag;
    logic [7:0] expSum;
    logic       expCarry;
    logic       expErr;
  } item_t;

  item_t sbQ[$];
  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  task automatic report(input string tag, input logic [9:0] act, input logic [9:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: opA=%h opB=%h cin=%0d actual={err,carry,sum}=%h expected=%h",
               tag, opA, opB, carryIn, act, exp);
    end
  endtask

  function automatic logic [7:0] toBcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  // Driver: apply stimulus on the falling edge, push the expected result
  task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic c, input string tag);
    item_t it;
    int total;
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    it.tag = tag;
    if (a[7:4] > 9 || a[3:0] > 9 || b[7:4] > 9 || b[3:0] > 9) begin
      it.expSum = 8'h00; it.expCarry = 1'b0; it.expErr = 1'b1;
    end else begin
      total = int'(a[7:4]) * 10 + int'(a[3:0]) + int'(b[7:4]) * 10 + int'(b[3:0]) + int'(c);
      it.expCarry = (total >= 100);
      it.expSum   = toBcd(total % 100);
      it.expErr   = 1'b0;
    end
    sbQ.push_back(it);
  endtask

  // Monitor: compare at the rising edge, half a period after the change
  item_t cur;
  always @(posedge clk) begin
    if (sbQ.size() > 0) begin
      cur = sbQ.pop_front();
      report(cur.tag, {1'b0, carryOut, sumOut}, {1'b0, cur.expCarry, cur.expSum});
      report(cur.expErr ? "R2 flag" : "R3 flag", {errFlag, 9'd0}, {cur.expErr, 9'd0});
      report({"R6 binary path / ", cur.tag}, {errBin, carryBin, sumBin},
             {cur.expErr, cur.expCarry, cur.expSum});
    end
  end

  initial begin
    opA = 8'h00; opB = 8'h00; carryIn = 1'b0;
    // Reset-like idle state: zero inputs give zero outputs, flag low
    drive(8'h00, 8'h00, 1'b0, "R1 idle zero");
    drive(8'h99, 8'h99, 1'b1, "R4 maximum");
    drive(8'h05, 8'h05, 1'b0, "R5 units carry");
    drive(8'h09, 8'h09, 1'b1, "R5 nibble wrap");
    drive(8'h08, 8'h08, 1'b0, "R5 sixteen");
    drive(8'h49, 8'h50, 1'b1, "R5 ripple to hundreds");
    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b++)
        for (int c = 0; c < 2; c++)
          drive(toBcd(a), toBcd(b), c[0], "R1 sweep");
    for (int pos = 0; pos < 4; pos++) begin
      for (int bad = 10; bad < 16; bad++) begin
        logic [15:0] ops;
        ops = 16'h4567;
        ops[pos*4 +: 4] = 4'(bad);
        drive(ops[15:8], ops[7:0], bad[0], "R2 invalid nibble");
      end
    end
    drive(8'hFF, 8'hFF, 1'b1, "R2 all invalid");
    drive(8'h99, 8'h9A, 1'b1, "R2 near maximum");
    wait (sbQ.size() == 0);
    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #600000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R1 watchdog: actual=still running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule